// File: doc/BRIEF.md
# Parallel-Word PRBS Verifier

This block checks a pseudo-random bit sequence that arrives as parallel words, one word on every cycle of the receive word clock. It learns the incoming pattern by predicting each new word from the bits it has already received. After a run of consecutive correct predictions it switches to its own free-running generator. It then checks one whole period of the polynomial before it raises a completion flag.

Once the flag is up, any word that differs from the expected pattern in one or more bits produces a stretched error pulse and bumps a saturating error total. Mismatches seen before completion are dropped silently. A clear input, or the synchronous reset, restarts the whole learn, lock and pass sequence. Word width, polynomial degree (7 or 31), the lock run length and the width of the error total are parameters.

Top module: `prbs_word_checker`

## Requirements
- R1: The serial sequence obeys b[n] = b[n-N] XOR b[n-T], with N=7, T=6 for the degree-7 polynomial and N=31, T=28 for the degree-31 polynomial. Bit 0 of `rx_word` is the earliest bit of a word in time.
- R2: Lock is declared on the LOCK_WORDS-th consecutive word whose bits all equal the prediction made from the N most recently received bits. Any mismatching word sets the run back to zero. After lock, predictions come from the internal generator and no longer from received data.
- R3: `pass_done` rises in the cycle after the PASS_WORDS-th word following the lock word, where PASS_WORDS = ceil((2^N-1)/WIDTH). It then stays high until a clear or reset.
- R4: Before `pass_done` is high, mismatching words never raise `word_err` and never change `err_total`.
- R5: A mismatching word accepted while `pass_done` is high drives `word_err` high for exactly three cycles, starting in the cycle after that word.
- R6: A word counts as one error event whatever the number of its mismatching bits, so `err_total` grows by at most one per word.
- R7: An error word that arrives while a pulse is still running restarts the three-cycle count from that word.
- R8: `err_total` increments once per error word and saturates at 2^CNT_W-1.
- R9: A word accepted with `pat_clear` high is not checked. In the next cycle `pass_done` is low and `err_total` is zero. Lock and the full pass must then be earned again, and a pulse already running is not cut short.
- R10: With `rst` high at a clock edge, `pass_done`, `word_err` and `err_total` are all zero in the next cycle, and tracking restarts as after a clear.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Parallel receive word clock |
| rst | input | 1 | Synchronous active-high reset |
| pat_clear | input | 1 | Restart tracking, drop completion, zero the error total |
| rx_word | input | WIDTH | Received data word, bit 0 earliest |
| pass_done | output | 1 | Lock reached and one full polynomial period checked |
| word_err | output | 1 | Stretched error pulse |
| err_total | output | CNT_W | Saturating count of error words |

## Verification
The main copy is built with 8-bit words, the degree-7 polynomial, a lock run of 4 and a 4-bit error total. With these values a full pass lasts only 16 words and the total saturates after 15 error words, so the exact cycle of completion, every pulse restart and the saturation point can each be reached many times in a short run. A second copy with 32-bit words and the degree-31 polynomial receives a corrupted stream, which shows that errors stay hidden during its very long first pass.

// File: rtl/prbs_chk_pkg.sv
package prbs_chk_pkg;

  localparam int HIST_MAX = 31;
  localparam int DATA_MAX = 64;

  typedef enum logic [1:0] {
    TRK_SEEK = 2'd0,
    TRK_PASS = 2'd1,
    TRK_DONE = 2'd2
  } trk_state_e;

  // second feedback tap of the supported polynomials
  function automatic int tap_of(input int deg);
    return (deg == 7) ? 6 : 28;
  endfunction

  // words needed to cover one full period of 2^deg-1 bits
  function automatic longint unsigned pass_words(input int deg, input int width);
    longint unsigned period;
    period = (64'd1 << deg) - 64'd1;
    return (period + longint'(width) - 64'd1) / longint'(width);
  endfunction

  function automatic logic [HIST_MAX-1:0] deg_mask(input int deg);
    return 31'h7fff_ffff >> (31 - deg);
  endfunction

  // shift a word into a history register, bit 0 first; h[0] is newest
  function automatic logic [HIST_MAX-1:0] hist_push(input logic [HIST_MAX-1:0] h,
                                                    input logic [DATA_MAX-1:0] w,
                                                    input int width, input int deg);
    logic [HIST_MAX-1:0] r;
    r = h;
    for (int i = 0; i < DATA_MAX; i++)
      if (i < width) r = {r[HIST_MAX-2:0], w[6'(i)]};
    return r & deg_mask(deg);
  endfunction

  // predict the next word from a history
  function automatic logic [DATA_MAX-1:0] lfsr_word(input logic [HIST_MAX-1:0] h,
                                                    input int width, input int deg,
                                                    input int tap);
    logic [DATA_MAX-1:0] p;
    logic [HIST_MAX-1:0] r;
    logic nb;
    p = '0;
    r = h;
    for (int i = 0; i < DATA_MAX; i++) begin
      if (i < width) begin
        nb = r[5'(deg - 1)] ^ r[5'(tap - 1)];
        p[6'(i)] = nb;
        r = {r[HIST_MAX-2:0], nb};
      end
    end
    return p;
  endfunction

endpackage

// File: rtl/prbs_predict.sv
module prbs_predict
  import prbs_chk_pkg::*;
#(
  parameter int WIDTH = 32,
  parameter int DEG   = 31,
  parameter int TAP   = 28
) (
  input  logic [DEG-1:0]   hist_i,
  output logic [WIDTH-1:0] pred_o,
  output logic [DEG-1:0]   hist_next_o
);
  logic [HIST_MAX-1:0] h_full;
  logic [DATA_MAX-1:0] p_full;

  assign h_full      = HIST_MAX'(hist_i);
  assign p_full      = lfsr_word(h_full, WIDTH, DEG, TAP);
  assign pred_o      = WIDTH'(p_full);
  assign hist_next_o = DEG'(hist_push(h_full, p_full, WIDTH, DEG));
endmodule

// File: rtl/prbs_align.sv
module prbs_align
  import prbs_chk_pkg::*;
#(
  parameter int              WIDTH      = 32,
  parameter int              DEG        = 31,
  parameter int              TAP        = 28,
  parameter int              LOCK_WORDS = 4,
  parameter longint unsigned PASS_WORDS = 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr_i,
  input  logic [WIDTH-1:0] rx_word_i,
  output logic             done_o,
  output logic             bad_word_o
);
  localparam int MC_W = $clog2(LOCK_WORDS + 1);
  localparam int PC_W = $clog2(PASS_WORDS + 1);

  trk_state_e       st;
  logic [DEG-1:0]   rx_hist, loc_hist;
  logic [MC_W-1:0]  match_cnt;
  logic [PC_W-1:0]  pass_cnt;
  logic [WIDTH-1:0] pred_rx, pred_loc;
  logic [DEG-1:0]   rx_hist_nxt, loc_hist_nxt;
  logic             seek_hit, loc_miss;

  prbs_predict #(.WIDTH(WIDTH), .DEG(DEG), .TAP(TAP)) u_pred_rx (
    .hist_i(rx_hist), .pred_o(pred_rx), .hist_next_o(rx_hist_nxt)
  );
  prbs_predict #(.WIDTH(WIDTH), .DEG(DEG), .TAP(TAP)) u_pred_loc (
    .hist_i(loc_hist), .pred_o(pred_loc), .hist_next_o(loc_hist_nxt)
  );

  assign seek_hit = (rx_word_i == pred_rx);
  assign loc_miss = (rx_word_i != pred_loc);

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= TRK_SEEK;
      rx_hist   <= '0;
      loc_hist  <= '0;
      match_cnt <= '0;
      pass_cnt  <= '0;
    end else begin
      rx_hist <= DEG'(hist_push(HIST_MAX'(rx_hist), DATA_MAX'(rx_word_i), WIDTH, DEG));
      if (clr_i) begin
        st        <= TRK_SEEK;
        match_cnt <= '0;
        pass_cnt  <= '0;
      end else begin
        unique case (st)
          TRK_SEEK: begin
            if (!seek_hit) begin
              match_cnt <= '0;
            end else if (match_cnt == MC_W'(LOCK_WORDS - 1)) begin
              st        <= TRK_PASS;
              match_cnt <= '0;
              loc_hist  <= rx_hist_nxt;
            end else begin
              match_cnt <= match_cnt + 1'b1;
            end
          end
          TRK_PASS: begin
            loc_hist <= loc_hist_nxt;
            if (pass_cnt == PC_W'(PASS_WORDS - 1)) st <= TRK_DONE;
            else pass_cnt <= pass_cnt + 1'b1;
          end
          default: loc_hist <= loc_hist_nxt;
        endcase
      end
    end
  end

  assign done_o     = (st == TRK_DONE);
  assign bad_word_o = done_o && loc_miss && !clr_i;

  // R3: completion is sticky while no clear arrives
  p_done_holds_r3: assert property (@(posedge clk) disable iff (rst)
    done_o && !clr_i |=> done_o);
  // R9: clear drops completion and the lock run
  p_clear_drops_done_r9: assert property (@(posedge clk) disable iff (rst)
    clr_i |=> !done_o && match_cnt == '0);
  // R2: lock never comes straight from a mismatching word
  p_lock_on_match_r2: assert property (@(posedge clk) disable iff (rst)
    st == TRK_SEEK && !seek_hit |=> st == TRK_SEEK);
endmodule

// File: rtl/prbs_err_pulse.sv
module prbs_err_pulse #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr_i,
  input  logic             start_i,
  output logic             err_o,
  output logic [CNT_W-1:0] total_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [1:0] left;

  always_ff @(posedge clk) begin
    if (rst) left <= 2'd0;
    else if (start_i) left <= 2'd3;
    else if (left != 2'd0) left <= left - 2'd1;
  end

  always_ff @(posedge clk) begin
    if (rst || clr_i) total_o <= '0;
    else if (start_i && total_o != CNT_MAX) total_o <= total_o + 1'b1;
  end

  assign err_o = (left != 2'd0);

  // R5 / R7: every error event yields three high cycles from the next one
  p_pulse_three_r5: assert property (@(posedge clk) disable iff (rst)
    start_i |=> err_o ##1 err_o ##1 err_o);
  // R5: a pulse with no new event ends after three cycles
  p_pulse_ends_r5: assert property (@(posedge clk) disable iff (rst)
    $rose(err_o) ##1 !start_i ##1 !start_i ##1 !start_i |=> !err_o);
  // R6: the total moves by at most one per word
  p_one_per_word_r6: assert property (@(posedge clk) disable iff (rst)
    !clr_i |=> (total_o == $past(total_o) || total_o == $past(total_o) + 1'b1));
  // R8: a saturated total stays put
  p_saturate_r8: assert property (@(posedge clk) disable iff (rst)
    total_o == CNT_MAX && !clr_i |=> total_o == CNT_MAX);
  // R10: reset silences the pulse and zeroes the total
  p_rst_clears_r10: assert property (@(posedge clk)
    rst |=> !err_o && total_o == '0);
endmodule

// File: rtl/prbs_word_checker.sv
module prbs_word_checker
  import prbs_chk_pkg::*;
#(
  parameter int WIDTH      = 32,
  parameter int POLY_DEG   = 31,
  parameter int LOCK_WORDS = 4,
  parameter int CNT_W      = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             pat_clear,
  input  logic [WIDTH-1:0] rx_word,
  output logic             pass_done,
  output logic             word_err,
  output logic [CNT_W-1:0] err_total
);
  localparam int              TAP        = tap_of(POLY_DEG);
  localparam longint unsigned PASS_WORDS = pass_words(POLY_DEG, WIDTH);

  logic bad_word;

  prbs_align #(
    .WIDTH(WIDTH), .DEG(POLY_DEG), .TAP(TAP),
    .LOCK_WORDS(LOCK_WORDS), .PASS_WORDS(PASS_WORDS)
  ) u_align (
    .clk(clk), .rst(rst), .clr_i(pat_clear), .rx_word_i(rx_word),
    .done_o(pass_done), .bad_word_o(bad_word)
  );

  prbs_err_pulse #(.CNT_W(CNT_W)) u_pulse (
    .clk(clk), .rst(rst), .clr_i(pat_clear), .start_i(bad_word),
    .err_o(word_err), .total_o(err_total)
  );

  // R4: a pulse can only begin once completion was already reported
  p_err_after_done_r4: assert property (@(posedge clk) disable iff (rst)
    $rose(word_err) |-> $past(pass_done));
  // R4: the total never moves while completion is low
  p_total_frozen_r4: assert property (@(posedge clk) disable iff (rst)
    !pass_done && !pat_clear |=> err_total == $past(err_total));
endmodule

// File: tb/prbs_word_checker_tb.sv
`timescale 1ns/1ps
module prbs_word_checker_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        clr = 1'b0;
  logic [7:0]  rx  = '0;
  logic [31:0] rx31 = '0;
  logic        done, err, done31, err31;
  logic [3:0]  tot;
  logic [31:0] tot31;

  int checks = 0;
  int fails  = 0;
  bit seq7 [127];
  int k = 0;
  logic [30:0] s31 = 31'h0000_1234;
  int left  = 0;
  int cnt_m = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  prbs_word_checker #(.WIDTH(8), .POLY_DEG(7), .LOCK_WORDS(4), .CNT_W(4)) u_dut (
    .clk(clk), .rst(rst), .pat_clear(clr), .rx_word(rx),
    .pass_done(done), .word_err(err), .err_total(tot)
  );

  prbs_word_checker #(.WIDTH(32), .POLY_DEG(31), .LOCK_WORDS(4), .CNT_W(32)) u_dut31 (
    .clk(clk), .rst(rst), .pat_clear(clr), .rx_word(rx31),
    .pass_done(done31), .word_err(err31), .err_total(tot31)
  );

  function automatic logic [7:0] word7(input int idx);
    logic [7:0] w;
    for (int i = 0; i < 8; i++) w[i] = seq7[(8 * idx + i) % 127];
    return w;
  endfunction

  task automatic adv31(output logic [31:0] w);
    logic nb;
    for (int i = 0; i < 32; i++) begin
      nb   = s31[30] ^ s31[27];
      w[i] = nb;
      s31  = {s31[29:0], nb};
    end
  endtask

  task automatic expect_eq(input string req, input string what,
                           input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: got %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic send(input logic [7:0] mask, input bit c, input bit inj31);
    logic [31:0] w31;
    adv31(w31);
    rx   = word7(k) ^ mask;
    rx31 = inj31 ? (w31 ^ 32'h0000_0120) : w31;
    clr  = c;
    k++;
    @(negedge clk);
    clr = 1'b0;
    expect_eq("R4", "wide err", longint'(err31), 0);
    expect_eq("R3", "wide done", longint'(done31), 0);
  endtask

  // word after completion, with the pulse and total model
  task automatic post(input logic [7:0] mask, input string req);
    send(mask, 1'b0, mask != 0);
    if (mask != 0) begin
      left = 3;
      if (cnt_m < 15) cnt_m++;
    end
    expect_eq(req, "err", longint'(err), longint'(left > 0));
    expect_eq(req, "total", longint'(tot), cnt_m);
    if (left > 0) left--;
  endtask

  initial begin
    for (int n = 0; n < 127; n++) seq7[n] = (n == 0);
    for (int n = 7; n < 127; n++) seq7[n] = seq7[n - 7] ^ seq7[n - 6];
  end

  initial begin
    repeat (3) @(negedge clk);
    expect_eq("R10", "reset done", longint'(done), 0);
    expect_eq("R10", "reset err", longint'(err), 0);
    expect_eq("R10", "reset total", longint'(tot), 0);
    rst = 1'b0;

    // first lock and pass: words 1..4 lock, 5..20 pass; word 10 corrupted
    for (int j = 0; j <= 20; j++) begin
      send((j == 10) ? 8'hFF : 8'h00, 1'b0, (j % 7) == 3);
      expect_eq("R1", "done timing", longint'(done), longint'(j == 20));
      expect_eq("R4", "err before done", longint'(err), 0);
      expect_eq("R4", "total before done", longint'(tot), 0);
    end

    for (int j = 0; j < 3; j++) post(8'h00, "R5");
    post(8'h01, "R5");
    for (int j = 0; j < 3; j++) post(8'h00, "R5");
    post(8'hFF, "R6");
    for (int j = 0; j < 3; j++) post(8'h00, "R6");
    post(8'h80, "R7");
    post(8'h00, "R7");
    post(8'h02, "R7");
    for (int j = 0; j < 4; j++) post(8'h00, "R7");
    post(8'h40, "R6");
    post(8'h21, "R6");
    for (int j = 0; j < 20; j++) post(8'(j + 1), "R8");
    for (int j = 0; j < 3; j++) post(8'h00, "R8");

    // clear while a pulse runs
    post(8'h10, "R9");
    send(8'h00, 1'b1, 1'b0);
    cnt_m = 0;
    expect_eq("R9", "done after clear", longint'(done), 0);
    expect_eq("R9", "total after clear", longint'(tot), 0);
    expect_eq("R9", "pulse kept", longint'(err), longint'(left > 0));
    if (left > 0) left--;
    for (int j = 0; j < 2; j++) begin
      send(8'h00, 1'b0, 1'b0);
      expect_eq("R9", "pulse tail", longint'(err), longint'(left > 0));
      if (left > 0) left--;
    end
    // broken run: the bit-0 flip only spoils its own word
    send(8'h01, 1'b0, 1'b0);
    expect_eq("R4", "seek mismatch hidden", longint'(err), 0);
    for (int j = 1; j <= 20; j++) begin
      send(8'h00, 1'b0, 1'b0);
      expect_eq("R2", "relock done timing", longint'(done), longint'(j == 20));
      expect_eq("R4", "err during relock", longint'(err), 0);
    end

    // reset in the middle of a pulse
    post(8'h04, "R10");
    rst = 1'b1;
    @(negedge clk);
    expect_eq("R10", "err after reset", longint'(err), 0);
    expect_eq("R10", "total after reset", longint'(tot), 0);
    expect_eq("R10", "done after reset", longint'(done), 0);
    rst = 1'b0;
    left = 0;
    cnt_m = 0;
    send(8'hFF, 1'b0, 1'b1);
    expect_eq("R10", "err after reset word", longint'(err), 0);

    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog: got 0 expected 1 (run completion)");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule